// File: doc/BRIEF.md
# Reset Release Sequencer

This block decides when each reset domain of a multi-core processor subsystem may leave reset. It takes an active-low power-on reset and cold and warm reset requests from a configuration controller. It also takes a cluster release request and per-core release requests from a power-management agent. From these it drives separate active-low resets for the general subsystem logic, the shared cluster unit, the interconnect bridge, each peripheral and each CPU core. Every output asserts at once, with no clock, when a reset input asserts. Every output deasserts on a boot-clock edge.

The order of release is fixed. The cold level clears first and the warm level next, and the general subsystem logic leaves reset only then. The shared cluster unit waits for the power-manager cluster request. A core leaves reset once the cluster is out of reset and either its own release bit or its own power-manager request is active. A release bit clears itself a fixed number of cycles after its core has left reset. The bridge and the peripherals leave reset only when software clears their reset bits. A word-addressed register port holds the release bits, the bridge and peripheral reset bits, and a low and a high boot-address word for each core.

Top module: `rst_release_seq`

## Requirements
- R1: While `por_n` is low, every reset output is low. After power-on reset, the release register (address 0) and every boot-address word read 0.
- R2: While `cold_req` is high, no output is released, whatever `warm_req` does. When `cold_req` falls while `warm_req` is already low, `sys_rst_n` rises at the 5th rising clock edge after the fall.
- R3: When `warm_req` falls while the cold level is already clear, `sys_rst_n` rises at the 4th rising edge after the fall. The cluster, bridge, peripheral and core resets stay low.
- R4: Once `sys_rst_n` is high, `cluster_rst_n` rises at the 3rd rising edge after `pm_cluster_rel` rises. It then stays high until the next cold or warm request.
- R5: `bridge_rst_n` is high only while `cluster_rst_n` is high and the bridge bit (address 1, bit 0, reset value 1) reads 0. It rises on the edge after the later of these two conditions.
- R6: Writing 1 to bit i of the release register (address 0; writes set bits, zeros are ignored) releases core i at the edge after the write edge, provided the cluster is out of reset. If the bit is written before the cluster is out of reset, core i is released on the edge after `cluster_rst_n` rises. Cores whose bit is not set stay in reset.
- R7: When `pm_core_rel[i]` rises while the cluster is out of reset, `core_rst_n[i]` rises at the 3rd rising edge. The other cores stay in reset.
- R8: A release bit reads 1 through the 15th rising edge after its core's reset rises, and reads 0 from the 16th rising edge on. The core stays released.
- R9: Core i has a low boot-address word at address 4+2i and a high word at address 5+2i. Both reset to 0, and both can be written and read back independently.
- R10: Peripheral bit j (address 2, reset value all ones) holds `periph_rst_n[j]` low. Writing 0 to bit j releases that peripheral at the edge after the write, while the system is out of reset. Peripherals whose bit still reads 1 stay in reset.
- R11: Raising `cold_req` or `warm_req` drives every output low at once, without a clock edge. The bridge and peripheral bits return to all ones. A warm request keeps the boot-address words. A cold request clears the boot-address words and the release register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Boot clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cold_req | input | 1 | Cold reset request, active high, asynchronous |
| warm_req | input | 1 | Warm reset request, active high, asynchronous |
| pm_cluster_rel | input | 1 | Power-manager cluster release request |
| pm_core_rel | input | NUM_CORES | Power-manager per-core release requests |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational from `reg_addr`) |
| sys_rst_n | output | 1 | General subsystem reset, active low |
| cluster_rst_n | output | 1 | Shared cluster reset, active low |
| bridge_rst_n | output | 1 | Interconnect bridge reset, active low |
| periph_rst_n | output | NUM_PERIPH | Peripheral resets, active low |
| core_rst_n | output | NUM_CORES | Per-core resets, active low |

## Verification
Asynchronous inputs pass through a two-flop synchroniser and then a level register, so a falling warm request releases the system at the 4th edge and a falling cold request at the 5th. A power-manager request takes effect at the 3rd edge. A register write is seen at the edge after its write edge, and a self-clearing release bit drops at the 16th edge after its core leaves reset. The bench drives inputs on falling edges and counts rising edges from the stimulus. It samples one cycle before each due edge, where the old value must still hold, and again just after the due edge, where the new value must appear. Assertion of a reset is checked a moment after the input changes, with no clock edge in between.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   typedef enum logic [1:0] {
      LVL_COLD = 2'd0,
      LVL_WARM = 2'd1,
      LVL_RUN  = 2'd2
   } lvl_e;

   localparam int unsigned RA_CORE_REL  = 0;
   localparam int unsigned RA_BRIDGE    = 1;
   localparam int unsigned RA_PERIPH    = 2;
   localparam int unsigned RA_BOOT_BASE = 4;
endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
   parameter int unsigned   W       = 1,
   parameter int unsigned   STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rrs_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(STAGES); k++) st[k] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int k = 1; k < int'(STAGES); k++) st[k] <= st[k-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/rrs_level_ctrl.sv
module rrs_level_ctrl
   import rrs_pkg::*;
(
   input  logic clk,
   input  logic por_n,
   input  logic out_arst_n,
   input  logic cold_s,
   input  logic warm_s,
   input  logic cluster_req_s,
   output lvl_e lvl,
   output logic sys_q,
   output logic cluster_q
);
   lvl_e lvl_nx;

   always_comb begin
      lvl_nx = lvl;
      if (cold_s) begin
         lvl_nx = LVL_COLD;
      end else begin
         case (lvl)
            LVL_COLD: lvl_nx = LVL_WARM;
            LVL_WARM: if (!warm_s) lvl_nx = LVL_RUN;
            LVL_RUN:  if (warm_s)  lvl_nx = LVL_WARM;
            default:  lvl_nx = LVL_COLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) lvl <= LVL_COLD;
      else        lvl <= lvl_nx;
   end

   always_ff @(posedge clk or negedge out_arst_n) begin
      if (!out_arst_n) begin
         sys_q     <= 1'b0;
         cluster_q <= 1'b0;
      end else begin
         sys_q     <= (lvl == LVL_RUN);
         cluster_q <= (lvl == LVL_RUN) && (cluster_q || cluster_req_s);
      end
   end
endmodule

// File: rtl/rrs_core_gate.sv
module rrs_core_gate #(
   parameter int unsigned SELF_CLR_CYC = 16
) (
   input  logic clk,
   input  logic arst_n,
   input  logic cluster_q,
   input  logic rel_bit,
   input  logic pm_req_s,
   output logic core_q,
   output logic rel_clr
);
   localparam int unsigned CNT_W = $clog2(SELF_CLR_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SELF_CLR_CYC - 1);

   if (SELF_CLR_CYC < 2) begin : g_bad_cyc
      $error("rrs_core_gate: SELF_CLR_CYC must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             done;

   assign rel_clr = core_q && !done && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         core_q <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
      end else begin
         core_q <= cluster_q && (core_q || rel_bit || pm_req_s);
         if (!core_q) begin
            cnt  <= '0;
            done <= 1'b0;
         end else if (rel_clr) begin
            done <= 1'b1;
         end else if (!done) begin
            cnt  <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rrs_regs.sv
module rrs_regs
   import rrs_pkg::*;
#(
   parameter int unsigned NUM_CORES  = 4,
   parameter int unsigned NUM_PERIPH = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_ADDR_W = 4
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  lvl_e                  lvl,
   input  logic                  we,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [NUM_CORES-1:0]  rel_clr,
   output logic [DATA_W-1:0]     rdata,
   output logic [NUM_CORES-1:0]  rel_bits,
   output logic                  bridge_bit,
   output logic [NUM_PERIPH-1:0] periph_bits
);
   logic [DATA_W-1:0] boot_lo [NUM_CORES];
   logic [DATA_W-1:0] boot_hi [NUM_CORES];

   function automatic logic hit(input logic [REG_ADDR_W-1:0] a, input int unsigned idx);
      return int'(a) == int'(idx);
   endfunction

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rel_bits <= '0;
      end else if (lvl == LVL_COLD) begin
         rel_bits <= '0;
      end else begin
         rel_bits <= (rel_bits & ~rel_clr)
                   | ((we && hit(addr, RA_CORE_REL)) ? wdata[NUM_CORES-1:0] : '0);
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         bridge_bit  <= 1'b1;
         periph_bits <= '1;
      end else if (lvl != LVL_RUN) begin
         bridge_bit  <= 1'b1;
         periph_bits <= '1;
      end else if (we) begin
         if (hit(addr, RA_BRIDGE)) bridge_bit  <= wdata[0];
         if (hit(addr, RA_PERIPH)) periph_bits <= wdata[NUM_PERIPH-1:0];
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_boot
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            boot_lo[c] <= '0;
            boot_hi[c] <= '0;
         end else if (lvl == LVL_COLD) begin
            boot_lo[c] <= '0;
            boot_hi[c] <= '0;
         end else if (we) begin
            if (hit(addr, RA_BOOT_BASE + 2*c))     boot_lo[c] <= wdata;
            if (hit(addr, RA_BOOT_BASE + 2*c + 1)) boot_hi[c] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit(addr, RA_CORE_REL)) rdata[NUM_CORES-1:0]  = rel_bits;
      if (hit(addr, RA_BRIDGE))   rdata[0]              = bridge_bit;
      if (hit(addr, RA_PERIPH))   rdata[NUM_PERIPH-1:0] = periph_bits;
      for (int c = 0; c < int'(NUM_CORES); c++) begin
         if (hit(addr, RA_BOOT_BASE + 2*c))     rdata = boot_lo[c];
         if (hit(addr, RA_BOOT_BASE + 2*c + 1)) rdata = boot_hi[c];
      end
   end
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
   import rrs_pkg::*;
#(
   parameter int unsigned NUM_CORES    = 4,
   parameter int unsigned NUM_PERIPH   = 8,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned REG_ADDR_W   = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned SELF_CLR_CYC = 16
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic                  cold_req,
   input  logic                  warm_req,
   input  logic                  pm_cluster_rel,
   input  logic [NUM_CORES-1:0]  pm_core_rel,
   input  logic                  reg_we,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic                  sys_rst_n,
   output logic                  cluster_rst_n,
   output logic                  bridge_rst_n,
   output logic [NUM_PERIPH-1:0] periph_rst_n,
   output logic [NUM_CORES-1:0]  core_rst_n
);
   localparam int unsigned SW = NUM_CORES + 3;
   localparam logic [SW-1:0] SYNC_RST = {{NUM_CORES{1'b0}}, 3'b011};

   if (NUM_CORES < 1 || NUM_CORES > DATA_W) begin : g_bad_cores
      $error("rst_release_seq: NUM_CORES out of range");
   end
   if (NUM_PERIPH < 1 || NUM_PERIPH > DATA_W) begin : g_bad_periph
      $error("rst_release_seq: NUM_PERIPH out of range");
   end
   if (RA_BOOT_BASE + 2*NUM_CORES > (1 << REG_ADDR_W)) begin : g_bad_addr
      $error("rst_release_seq: REG_ADDR_W too narrow for the boot words");
   end

   logic                  out_arst_n;
   logic [SW-1:0]         sync_q;
   logic                  cold_s, warm_s, cluster_req_s;
   logic [NUM_CORES-1:0]  pm_core_s;
   lvl_e                  lvl;
   logic                  sys_q, cluster_q, bridge_q;
   logic [NUM_PERIPH-1:0] periph_q;
   logic [NUM_CORES-1:0]  core_q, rel_clr, rel_bits;
   logic                  bridge_bit;
   logic [NUM_PERIPH-1:0] periph_bits;

   assign out_arst_n = por_n & ~cold_req & ~warm_req;

   rrs_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     ({pm_core_rel, pm_cluster_rel, warm_req, cold_req}),
      .q     (sync_q)
   );
   assign cold_s        = sync_q[0];
   assign warm_s        = sync_q[1];
   assign cluster_req_s = sync_q[2];
   assign pm_core_s     = sync_q[SW-1:3];

   rrs_level_ctrl u_lvl (
      .clk           (clk),
      .por_n         (por_n),
      .out_arst_n    (out_arst_n),
      .cold_s        (cold_s),
      .warm_s        (warm_s),
      .cluster_req_s (cluster_req_s),
      .lvl           (lvl),
      .sys_q         (sys_q),
      .cluster_q     (cluster_q)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      rrs_core_gate #(.SELF_CLR_CYC(SELF_CLR_CYC)) u_gate (
         .clk       (clk),
         .arst_n    (out_arst_n),
         .cluster_q (cluster_q),
         .rel_bit   (rel_bits[c]),
         .pm_req_s  (pm_core_s[c]),
         .core_q    (core_q[c]),
         .rel_clr   (rel_clr[c])
      );
   end

   rrs_regs #(
      .NUM_CORES  (NUM_CORES),
      .NUM_PERIPH (NUM_PERIPH),
      .DATA_W     (DATA_W),
      .REG_ADDR_W (REG_ADDR_W)
   ) u_regs (
      .clk         (clk),
      .por_n       (por_n),
      .lvl         (lvl),
      .we          (reg_we),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .rel_clr     (rel_clr),
      .rdata       (reg_rdata),
      .rel_bits    (rel_bits),
      .bridge_bit  (bridge_bit),
      .periph_bits (periph_bits)
   );

   always_ff @(posedge clk or negedge out_arst_n) begin
      if (!out_arst_n) begin
         bridge_q <= 1'b0;
         periph_q <= '0;
      end else begin
         bridge_q <= cluster_q & ~bridge_bit;
         periph_q <= {NUM_PERIPH{lvl == LVL_RUN}} & ~periph_bits;
      end
   end

   assign sys_rst_n     = sys_q;
   assign cluster_rst_n = cluster_q;
   assign bridge_rst_n  = bridge_q;
   assign periph_rst_n  = periph_q;
   assign core_rst_n    = core_q;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
   parameter int unsigned NUM_CORES  = 4,
   parameter int unsigned NUM_PERIPH = 8
) (
   input logic                  clk,
   input logic                  por_n,
   input logic                  cold_req,
   input logic                  warm_req,
   input logic                  sys_rst_n,
   input logic                  cluster_rst_n,
   input logic                  bridge_rst_n,
   input logic [NUM_PERIPH-1:0] periph_rst_n,
   input logic [NUM_CORES-1:0]  core_rst_n
);
   always @(negedge clk) begin
      if (por_n === 1'b0) begin
         AST_POR_HOLDS_ALL: assert (!sys_rst_n && !cluster_rst_n && !bridge_rst_n
                                    && periph_rst_n == '0 && core_rst_n == '0); // R1
      end
   end

   AST_COLD_HOLDS_ALL: assert property (@(posedge clk) disable iff (!por_n)
      cold_req |-> (!sys_rst_n && !cluster_rst_n && !bridge_rst_n
                    && periph_rst_n == '0 && core_rst_n == '0)); // R2

   AST_WARM_HOLDS_ALL: assert property (@(posedge clk) disable iff (!por_n)
      warm_req |-> (!sys_rst_n && !cluster_rst_n && core_rst_n == '0)); // R11

   AST_CLUSTER_NEEDS_SYS: assert property (@(posedge clk) disable iff (!por_n)
      cluster_rst_n |-> sys_rst_n); // R4

   AST_BRIDGE_NEEDS_CLUSTER: assert property (@(posedge clk) disable iff (!por_n)
      bridge_rst_n |-> cluster_rst_n); // R5

   AST_CORE_NEEDS_CLUSTER: assert property (@(posedge clk) disable iff (!por_n)
      (core_rst_n != '0) |-> cluster_rst_n); // R6

   AST_PERIPH_NEEDS_SYS: assert property (@(posedge clk) disable iff (!por_n)
      (periph_rst_n != '0) |-> sys_rst_n); // R10
endmodule

bind rst_release_seq rrs_checker #(
   .NUM_CORES  (NUM_CORES),
   .NUM_PERIPH (NUM_PERIPH)
) u_chk (
   .clk           (clk),
   .por_n         (por_n),
   .cold_req      (cold_req),
   .warm_req      (warm_req),
   .sys_rst_n     (sys_rst_n),
   .cluster_rst_n (cluster_rst_n),
   .bridge_rst_n  (bridge_rst_n),
   .periph_rst_n  (periph_rst_n),
   .core_rst_n    (core_rst_n)
);

// File: tb/tb_rst_release_seq.sv
`timescale 1ns/1ps
module tb_rst_release_seq;
   localparam int NC = 4;
   localparam int NP = 8;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          por_n, cold_req, warm_req, pm_cluster_rel;
   logic [NC-1:0] pm_core_rel;
   logic          reg_we;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] reg_wdata, reg_rdata;
   logic          sys_rst_n, cluster_rst_n, bridge_rst_n;
   logic [NP-1:0] periph_rst_n;
   logic [NC-1:0] core_rst_n;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   rst_release_seq #(.NUM_CORES(NC), .NUM_PERIPH(NP), .DATA_W(DW), .REG_ADDR_W(AW)) dut (
      .clk(clk), .por_n(por_n), .cold_req(cold_req), .warm_req(warm_req),
      .pm_cluster_rel(pm_cluster_rel), .pm_core_rel(pm_core_rel),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sys_rst_n(sys_rst_n), .cluster_rst_n(cluster_rst_n), .bridge_rst_n(bridge_rst_n),
      .periph_rst_n(periph_rst_n), .core_rst_n(core_rst_n)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] v);
      reg_addr = AW'(a);
      #0.5;
      v = reg_rdata;
   endtask

   task automatic chk_all_low(input string req, input string what);
      chk(req, {what, " sys"}, 64'(sys_rst_n), 64'd0);
      chk(req, {what, " cluster"}, 64'(cluster_rst_n), 64'd0);
      chk(req, {what, " bridge"}, 64'(bridge_rst_n), 64'd0);
      chk(req, {what, " periph"}, 64'(periph_rst_n), 64'd0);
      chk(req, {what, " core"}, 64'(core_rst_n), 64'd0);
   endtask

   // warm pulse: async assertion, then release; system out at the 4th edge
   task automatic do_warm();
      pm_cluster_rel = 1'b0; pm_core_rel = '0;
      warm_req = 1'b1;
      #0.5;
      chk_all_low("R11", "warm async");
      step(5);
      warm_req = 1'b0;
      step(3);
      chk("R3", "sys before 4th edge", 64'(sys_rst_n), 64'd0);
      step(1);
      chk("R3", "sys at 4th edge", 64'(sys_rst_n), 64'd1);
   endtask

   task automatic raise_cluster();
      pm_cluster_rel = 1'b1;
      step(2);
      chk("R4", "cluster before 3rd edge", 64'(cluster_rst_n), 64'd0);
      step(1);
      chk("R4", "cluster at 3rd edge", 64'(cluster_rst_n), 64'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      por_n = 1'b0; cold_req = 1'b1; warm_req = 1'b1;
      pm_cluster_rel = 1'b0; pm_core_rel = '0;
      reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      step(5);
      chk_all_low("R1", "por held");

      por_n = 1'b1;
      step(1);
      cold_req = 1'b0;
      step(6);
      chk("R2", "sys while warm held", 64'(sys_rst_n), 64'd0);
      rd(0, v); chk("R1", "release reg after por", 64'(v), 64'd0);
      for (int a = 4; a < 4 + 2*NC; a++) begin
         rd(a, v); chk("R9", "boot word reset", 64'(v), 64'd0);
      end
      rd(2, v); chk("R10", "periph bits reset", 64'(v), 64'(8'hFF));
      rd(1, v); chk("R5", "bridge bit reset", 64'(v), 64'd1);

      warm_req = 1'b0;
      step(3);
      chk("R3", "sys before 4th edge", 64'(sys_rst_n), 64'd0);
      step(1);
      chk("R3", "sys at 4th edge", 64'(sys_rst_n), 64'd1);
      step(5);
      chk("R3", "cluster held", 64'(cluster_rst_n), 64'd0);
      chk("R3", "bridge held", 64'(bridge_rst_n), 64'd0);
      chk("R3", "periph held", 64'(periph_rst_n), 64'd0);
      chk("R3", "core held", 64'(core_rst_n), 64'd0);

      raise_cluster();
      chk("R6", "cores stay in reset without request", 64'(core_rst_n), 64'd0);
      wr(1, 32'd0);
      chk("R5", "bridge before edge after write", 64'(bridge_rst_n), 64'd0);
      step(1);
      chk("R5", "bridge after write", 64'(bridge_rst_n), 64'd1);

      for (int p = 0; p < NP; p++) begin
         wr(2, 32'(~(8'd1 << p)));
         chk("R10", "periph before edge", 64'(periph_rst_n), (p == 0) ? 64'd0 : 64'(8'd1 << (p - 1)));
         step(1);
         chk("R10", "single periph released", 64'(periph_rst_n), 64'(8'd1 << p));
      end
      wr(2, 32'hFF);
      step(1);
      chk("R10", "periph back in reset", 64'(periph_rst_n), 64'd0);

      for (int i = 0; i < NC; i++) begin
         do_warm();
         rd(1, v); chk("R11", "bridge bit back to 1", 64'(v), 64'd1);
         rd(2, v); chk("R11", "periph bits back to ones", 64'(v), 64'(8'hFF));
         raise_cluster();
         wr(0, 32'(1 << i));
         chk("R6", "core before edge after write", 64'(core_rst_n), 64'd0);
         step(1);
         chk("R6", "only the written core released", 64'(core_rst_n), 64'(1 << i));
         step(15);
         rd(0, v); chk("R8", "release bit at 15th edge", 64'(v), 64'(1 << i));
         step(1);
         rd(0, v); chk("R8", "release bit at 16th edge", 64'(v), 64'd0);
         chk("R8", "core stays released", 64'(core_rst_n), 64'(1 << i));
      end

      for (int i = 0; i < NC; i++) begin
         do_warm();
         raise_cluster();
         pm_core_rel[i] = 1'b1;
         step(2);
         chk("R7", "pm core before 3rd edge", 64'(core_rst_n), 64'd0);
         step(1);
         chk("R7", "pm core at 3rd edge", 64'(core_rst_n), 64'(1 << i));
      end

      do_warm();
      wr(0, 32'h5);
      wr(1, 32'd0);
      step(3);
      chk("R6", "core waits for cluster", 64'(core_rst_n), 64'd0);
      chk("R5", "bridge waits for cluster", 64'(bridge_rst_n), 64'd0);
      raise_cluster();
      chk("R6", "core at cluster edge", 64'(core_rst_n), 64'd0);
      chk("R5", "bridge at cluster edge", 64'(bridge_rst_n), 64'd0);
      step(1);
      chk("R6", "cores after cluster", 64'(core_rst_n), 64'h5);
      chk("R5", "bridge after cluster", 64'(bridge_rst_n), 64'd1);

      for (int i = 0; i < NC; i++) begin
         wr(4 + 2*i, 32'hA5000000 + 32'(i * 32'h1111));
         wr(5 + 2*i, 32'h0000005A ^ 32'(i << 12));
      end
      for (int i = 0; i < NC; i++) begin
         rd(4 + 2*i, v); chk("R9", "boot low readback", 64'(v), 64'(32'hA5000000 + 32'(i * 32'h1111)));
         rd(5 + 2*i, v); chk("R9", "boot high readback", 64'(v), 64'(32'h0000005A ^ 32'(i << 12)));
      end
      do_warm();
      for (int i = 0; i < NC; i++) begin
         rd(4 + 2*i, v); chk("R11", "boot low kept by warm", 64'(v), 64'(32'hA5000000 + 32'(i * 32'h1111)));
         rd(5 + 2*i, v); chk("R11", "boot high kept by warm", 64'(v), 64'(32'h0000005A ^ 32'(i << 12)));
      end
      raise_cluster();
      wr(2, 32'h0);
      wr(0, 32'h8);
      step(2);

      cold_req = 1'b1;
      #0.5;
      chk_all_low("R11", "cold async");
      pm_cluster_rel = 1'b0; pm_core_rel = '0;
      step(6);
      for (int i = 0; i < NC; i++) begin
         rd(4 + 2*i, v); chk("R11", "boot low cleared by cold", 64'(v), 64'd0);
         rd(5 + 2*i, v); chk("R11", "boot high cleared by cold", 64'(v), 64'd0);
      end
      rd(0, v); chk("R11", "release reg cleared by cold", 64'(v), 64'd0);
      warm_req = 1'b1;
      step(4);
      warm_req = 1'b0;
      step(8);
      chk("R2", "sys held by cold after warm release", 64'(sys_rst_n), 64'd0);
      cold_req = 1'b0;
      step(4);
      chk("R2", "sys before 5th edge", 64'(sys_rst_n), 64'd0);
      step(1);
      chk("R2", "sys at 5th edge", 64'(sys_rst_n), 64'd1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule